// File: doc/BRIEF.md
# Planar Video and Overlay Compositor with Digital Video Stream Output

This block turns two picture layers into one serial 8-bit component video stream in the CCIR 656 style. It emits one byte per clock. The base layer arrives as planar video: two luma samples on one bus, plus one blue-difference sample and one red-difference sample, all presented together. The upper layer is a graphics overlay in which each 32-bit word holds one 4:2:2 pixel pair. For each pair the block takes one word from each layer. It merges the two layers per pixel with a constant alpha, and it can make overlay pixels transparent by matching them against a programmable colour range (chroma keying).

A programmable timing generator sets the line length, the horizontal blanking, the number of blanking lines and active lines per field, and whether the output is interlaced or progressive. It inserts the four-byte timing reference codes at both ends of the blanking interval of every line. The video layer can be widened by two, either by repeating samples or by interpolating between them. The overlay is never widened. The memory fetch logic and the sample clock generator are outside this block. They connect through the two `*_take` strobes: a source must present its next word in the cycle after a strobe.

Top module: `ccir_compositor`

## Requirements
- R1: While reset is held, `dout` is 0x10 and both `vid_take` and `ovl_take` are low.
- R2: Each line has the following byte positions, counted from 0. Positions 0 to 3 carry the end-of-active code. The next `cfg_hblank` bytes alternate 0x80 and 0x10, starting with 0x80. Four bytes of start-of-active code follow. Then come 2*`cfg_act_pix` active bytes, repeating Cb, Y0, Cr, Y1. A byte appears on `dout` one clock after the cycle that holds its position.
- R3: Each reference code is 0xFF, 0x00, 0x00, XY. In XY, bit 7 is 1, bit 6 is F, bit 5 is V and bit 4 is H (1 for end-of-active). Bits 3 to 0 are V^H, F^H, F^V and F^V^H.
- R4: A field has `cfg_vblank` blanking lines followed by `cfg_act_lines` active lines. In blanking lines V=1, and the active region is filled with 0x80 and 0x10 alternating. In progressive mode F is always 0. In interlaced mode F starts at 0 and toggles at every field boundary.
- R5: In active lines without upscaling, `vid_take` is high in the cycle of each Cb byte position. In that cycle the block samples `vid_y[7:0]` as Y0, `vid_y[15:8]` as Y1, and `vid_u` and `vid_v`.
- R6: When `cfg_upscale` is 1 and `cfg_up_avg` is 0, `vid_take` is high only for even-numbered pairs of the line. The even pair outputs luma Y0,Y0. The following odd pair outputs Y1,Y1. Both pairs reuse the same chroma.
- R7: When `cfg_upscale` and `cfg_up_avg` are both 1, the second luma of the even pair is (Y0+Y1+1)/2. The odd pair stays Y1,Y1.
- R8: When `cfg_ovl_en` is 1, `ovl_take` is high at every active pair, upscaled or not. The overlay word is laid out as bits [7:0] Cb, [15:8] Y0, [23:16] Cr, [31:24] Y1.
- R9: For an overlay pixel that is not keyed, each component is (a*ovl + (255-a)*vid + 127)/255, where a is `cfg_alpha`.
- R10: With `cfg_key_en` set, an overlay pixel is keyed when its Y, and the pair's Cb and Cr, lie within the inclusive ranges `cfg_key_lo..cfg_key_hi` (bytes [7:0] Y, [15:8] Cb, [23:16] Cr). A keyed pixel shows video only. Both chroma bytes follow the keying of pixel 0.
- R11: Every active byte is clipped: 0x00 becomes 0x01 and 0xFF becomes 0xFE.
- R12: When `cfg_ovl_en` is 0, `ovl_take` stays low and the output shows the video layer unchanged except for clipping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_act_pix | input | 12 | Active pixels per line (even) |
| cfg_hblank | input | 12 | Horizontal blanking bytes between the codes |
| cfg_vblank | input | 11 | Vertical blanking lines per field |
| cfg_act_lines | input | 11 | Active lines per field |
| cfg_interlace | input | 1 | 1: two fields per frame |
| cfg_upscale | input | 1 | 1: widen the video layer by two |
| cfg_up_avg | input | 1 | 1: interpolate instead of repeating when widening |
| cfg_ovl_en | input | 1 | Overlay layer enable |
| cfg_key_en | input | 1 | Chroma key enable |
| cfg_alpha | input | 8 | Overlay opacity |
| cfg_key_lo | input | 24 | Key lower bounds {Cr,Cb,Y} |
| cfg_key_hi | input | 24 | Key upper bounds {Cr,Cb,Y} |
| vid_y | input | 16 | Video luma pair {Y1,Y0} |
| vid_u | input | 8 | Video Cb sample |
| vid_v | input | 8 | Video Cr sample |
| vid_take | output | 1 | The video word is consumed this cycle |
| ovl_pix | input | 32 | Overlay pixel pair {Y1,Cr,Y0,Cb} |
| ovl_take | output | 1 | The overlay word is consumed this cycle |
| dout | output | 8 | Serial output byte |

## Verification
Keying and blending are decided in the same cycle, and they can give different answers for the two pixels of one pair. The bench uses overlay data whose luma crosses the key range from pixel to pixel, so one pixel of a pair is keyed while its neighbour is blended. Here the chroma must follow pixel 0. Upscaling also falls in the same cycle as a blend: an odd pair reuses held video data but takes a fresh overlay word. The scoreboard model predicts every byte and every strobe on its own, so a wrong luma, a misplaced strobe or chroma following the wrong pixel all show up as a byte mismatch.

// File: rtl/ccir_compositor.sv
module ccir_compositor #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_act_pix,
  input  logic [HW-1:0] cfg_hblank,
  input  logic [VW-1:0] cfg_vblank,
  input  logic [VW-1:0] cfg_act_lines,
  input  logic          cfg_interlace,
  input  logic          cfg_upscale,
  input  logic          cfg_up_avg,
  input  logic          cfg_ovl_en,
  input  logic          cfg_key_en,
  input  logic [7:0]    cfg_alpha,
  input  logic [23:0]   cfg_key_lo,
  input  logic [23:0]   cfg_key_hi,
  input  logic [15:0]   vid_y,
  input  logic [7:0]    vid_u,
  input  logic [7:0]    vid_v,
  output logic          vid_take,
  input  logic [31:0]   ovl_pix,
  output logic          ovl_take,
  output logic [7:0]    dout
);
  localparam int CW = HW + 2;
  localparam int LW = VW + 1;

  logic [CW-1:0] hc, line_len, sav_at, act_at;
  logic [LW-1:0] vc, fld_len;
  logic          fld;
  logic [2:0]    a;
  logic [1:0]    rs;

  assign line_len = CW'(8) + CW'(cfg_hblank) + {1'b0, cfg_act_pix, 1'b0};
  assign sav_at   = CW'(4) + CW'(cfg_hblank);
  assign act_at   = sav_at + CW'(4);
  assign fld_len  = LW'(cfg_vblank) + LW'(cfg_act_lines);
  assign a        = 3'(hc - act_at);
  assign rs       = 2'(hc - sav_at);

  wire line_end = hc == line_len - CW'(1);
  wire vb       = vc < LW'(cfg_vblank);
  wire in_act   = hc >= act_at;
  wire in_sav   = hc >= sav_at && !in_act;
  wire h        = hc < CW'(4);
  wire pair_go  = in_act && !vb && a[1:0] == 2'd0;
  wire vsrc     = pair_go && (!cfg_upscale || !a[2]);
  wire [7:0] xy = {1'b1, fld, vb, h, vb ^ h, fld ^ h, fld ^ vb, fld ^ vb ^ h};

  assign vid_take = vsrc;
  assign ovl_take = pair_go && cfg_ovl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc  <= '0;
      vc  <= '0;
      fld <= 1'b0;
    end else if (line_end) begin
      hc <= '0;
      if (vc == fld_len - LW'(1)) begin
        vc  <= '0;
        fld <= cfg_interlace ? ~fld : 1'b0;
      end else begin
        vc <= vc + LW'(1);
      end
    end else begin
      hc <= hc + CW'(1);
    end
  end

  logic [7:0] sy1, su, sv;
  logic [7:0] vy0, vy1, vu, vv;
  logic [8:0] ysum;

  assign ysum = {1'b0, vid_y[7:0]} + {1'b0, vid_y[15:8]} + 9'd1;

  always_comb begin
    vy0 = vid_y[7:0];
    vy1 = vid_y[15:8];
    vu  = vid_u;
    vv  = vid_v;
    if (cfg_upscale) begin
      if (vsrc) begin
        vy1 = cfg_up_avg ? ysum[8:1] : vid_y[7:0];
      end else begin
        vy0 = sy1;
        vy1 = sy1;
        vu  = su;
        vv  = sv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      su  <= '0;
      sv  <= '0;
    end else if (vsrc) begin
      sy1 <= vid_y[15:8];
      su  <= vid_u;
      sv  <= vid_v;
    end
  end

  function automatic logic in_rng(input logic [7:0] x, input logic [7:0] lo, input logic [7:0] hi);
    return x >= lo && x <= hi;
  endfunction

  function automatic logic [7:0] mix(input logic [7:0] o, input logic [7:0] v, input logic [7:0] al);
    logic [16:0] s;
    s = 17'(al) * 17'(o) + 17'(8'd255 - al) * 17'(v) + 17'd127;
    return 8'(s / 17'd255);
  endfunction

  function automatic logic [7:0] clip(input logic [7:0] x);
    return (x == 8'h00) ? 8'h01 : (x == 8'hFF) ? 8'hFE : x;
  endfunction

  wire [7:0] ou  = ovl_pix[7:0];
  wire [7:0] oy0 = ovl_pix[15:8];
  wire [7:0] ov  = ovl_pix[23:16];
  wire [7:0] oy1 = ovl_pix[31:24];

  wire kc   = in_rng(ou, cfg_key_lo[15:8], cfg_key_hi[15:8]) &&
              in_rng(ov, cfg_key_lo[23:16], cfg_key_hi[23:16]);
  wire k0   = cfg_key_en && kc && in_rng(oy0, cfg_key_lo[7:0], cfg_key_hi[7:0]);
  wire k1   = cfg_key_en && kc && in_rng(oy1, cfg_key_lo[7:0], cfg_key_hi[7:0]);
  wire use0 = cfg_ovl_en && !k0;
  wire use1 = cfg_ovl_en && !k1;

  wire [7:0] c_cb = clip(use0 ? mix(ou,  vu,  cfg_alpha) : vu);
  wire [7:0] c_y0 = clip(use0 ? mix(oy0, vy0, cfg_alpha) : vy0);
  wire [7:0] c_cr = clip(use0 ? mix(ov,  vv,  cfg_alpha) : vv);
  wire [7:0] c_y1 = clip(use1 ? mix(oy1, vy1, cfg_alpha) : vy1);

  logic [7:0] h_y0, h_cr, h_y1, nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_y0 <= '0;
      h_cr <= '0;
      h_y1 <= '0;
    end else if (pair_go) begin
      h_y0 <= c_y0;
      h_cr <= c_cr;
      h_y1 <= c_y1;
    end
  end

  always_comb begin
    if (h || in_sav) begin
      case (h ? hc[1:0] : rs)
        2'd0:    nb = 8'hFF;
        2'd3:    nb = xy;
        default: nb = 8'h00;
      endcase
    end else if (!in_act || vb) begin
      nb = (in_act ? a[0] : hc[0]) ? 8'h10 : 8'h80;
    end else begin
      case (a[1:0])
        2'd0:    nb = c_cb;
        2'd1:    nb = h_y0;
        2'd2:    nb = h_cr;
        default: nb = h_y1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 8'h10;
    else        dout <= nb;
  end

  // R11
  ff_then_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout == 8'hFF |=> dout == 8'h00);

  // R5
  take_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_take |=> !vid_take);

  // R6
  up_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upscale && $past(vid_take, 4) |-> !vid_take);

  // R3
  xy_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dout, 3) == 8'hFF && $past(dout, 2) == 8'h00 && $past(dout) == 8'h00 |->
    dout[7] && dout[3:0] == {dout[5] ^ dout[4], dout[6] ^ dout[4], dout[6] ^ dout[5], dout[6] ^ dout[5] ^ dout[4]});

  // R4
  prog_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_interlace && $past(dout, 3) == 8'hFF && $past(dout, 2) == 8'h00 && $past(dout) == 8'h00 |-> !dout[6]);
endmodule

// File: tb/test_ccir_compositor.sv
module test_ccir_compositor;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int t_act = 8, t_hb = 4, t_vb = 2, t_al = 3;
  bit t_int = 0, t_up = 0, t_avg = 0, t_ovl = 0, t_key = 0;
  int t_alpha = 0;
  logic [23:0] t_lo = 24'h0, t_hi = 24'h0;
  string act_tag = "R5";

  logic [15:0] vid_y;
  logic [7:0]  vid_u, vid_v, dout;
  logic [31:0] ovl_pix;
  logic        vid_take, ovl_take;
  int s_vi, s_oi;

  function automatic logic [31:0] vsrc_f(input int i);
    logic [7:0] y0, y1, u, v;
    y0 = 8'(i * 53 + 7);
    y1 = 8'(i * 29 + 250);
    u  = 8'(i * 71 + 128);
    v  = 8'(i * 13 + 64);
    if (i % 5 == 3) y0 = 8'h00;
    if (i % 5 == 4) y1 = 8'hFF;
    return {v, u, y1, y0};
  endfunction

  function automatic logic [31:0] osrc_f(input int i);
    logic [7:0] cb, y0, cr, y1;
    cb = 8'(i * 19 + 100);
    y0 = 8'(i * 41 + 30);
    cr = 8'(i * 23 + 90);
    y1 = 8'(i * 61 + 200);
    if (i % 6 == 2) begin cb = 8'hFF; y0 = 8'h00; end
    return {y1, cr, y0, cb};
  endfunction

  logic [31:0] vw;
  assign vw      = vsrc_f(s_vi);
  assign vid_y   = vw[15:0];
  assign vid_u   = vw[23:16];
  assign vid_v   = vw[31:24];
  assign ovl_pix = osrc_f(s_oi);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin s_vi <= 0; s_oi <= 0; end
    else begin
      if (vid_take) s_vi <= s_vi + 1;
      if (ovl_take) s_oi <= s_oi + 1;
    end
  end

  ccir_compositor i_ccir_compositor (
    .clk(clk), .rst_n(rst_n),
    .cfg_act_pix(12'(t_act)), .cfg_hblank(12'(t_hb)),
    .cfg_vblank(11'(t_vb)), .cfg_act_lines(11'(t_al)),
    .cfg_interlace(t_int), .cfg_upscale(t_up), .cfg_up_avg(t_avg),
    .cfg_ovl_en(t_ovl), .cfg_key_en(t_key), .cfg_alpha(8'(t_alpha)),
    .cfg_key_lo(t_lo), .cfg_key_hi(t_hi),
    .vid_y(vid_y), .vid_u(vid_u), .vid_v(vid_v), .vid_take(vid_take),
    .ovl_pix(ovl_pix), .ovl_take(ovl_take), .dout(dout)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  int m_hc, m_vc, m_vi, m_oi;
  bit m_f, running = 0, e_vt, e_ot;
  logic [7:0] m_y0, m_cr, m_y1, m_sy1, m_su, m_sv;
  logic [7:0] q[$];
  string tq[$];

  function automatic logic [7:0] blend(input logic [7:0] o, input logic [7:0] v);
    int s;
    s = (t_alpha * int'(o) + (255 - t_alpha) * int'(v) + 127) / 255;
    return 8'(s);
  endfunction

  function automatic logic [7:0] cl(input logic [7:0] x);
    if (x == 8'h00) return 8'h01;
    if (x == 8'hFF) return 8'hFE;
    return x;
  endfunction

  function automatic bit inr(input logic [7:0] x, input int sh);
    return x >= t_lo[sh +: 8] && x <= t_hi[sh +: 8];
  endfunction

  task automatic model_step(output logic [7:0] b, output string tag);
    int len, sav, aa;
    bit vb, h, use0, use1, kc;
    logic [7:0] vy0, vy1, vu, vv, ocb, oy0, ocr, oy1;
    logic [31:0] w;
    len = 8 + t_hb + 2 * t_act;
    sav = 4 + t_hb;
    vb  = m_vc < t_vb;
    h   = m_hc < 4;
    aa  = m_hc - sav - 4;
    if (h || (m_hc >= sav && m_hc < sav + 4)) begin
      tag = "R3";
      case ((h ? m_hc : m_hc - sav))
        0: b = 8'hFF;
        3: b = {1'b1, m_f, vb, h, vb ^ h, m_f ^ h, m_f ^ vb, m_f ^ vb ^ h};
        default: b = 8'h00;
      endcase
    end else if (m_hc < sav) begin
      tag = "R2";
      b = ((m_hc - 4) % 2 == 0) ? 8'h80 : 8'h10;
    end else if (vb) begin
      tag = "R4";
      b = (aa % 2 == 0) ? 8'h80 : 8'h10;
    end else begin
      tag = act_tag;
      if (aa % 4 == 0) begin
        if (!t_up || (aa / 4) % 2 == 0) begin
          w = vsrc_f(m_vi); m_vi++;
          vy0 = w[7:0]; vu = w[23:16]; vv = w[31:24];
          vy1 = !t_up ? w[15:8] : t_avg ? 8'((int'(w[7:0]) + int'(w[15:8]) + 1) / 2) : w[7:0];
          m_sy1 = w[15:8]; m_su = vu; m_sv = vv;
        end else begin
          vy0 = m_sy1; vy1 = m_sy1; vu = m_su; vv = m_sv;
        end
        use0 = 0; use1 = 0;
        if (t_ovl) begin
          w = osrc_f(m_oi); m_oi++;
          ocb = w[7:0]; oy0 = w[15:8]; ocr = w[23:16]; oy1 = w[31:24];
          kc = t_key && inr(ocb, 8) && inr(ocr, 16);
          use0 = !(kc && inr(oy0, 0));
          use1 = !(kc && inr(oy1, 0));
        end
        b    = cl(use0 ? blend(ocb, vu) : vu);
        m_y0 = cl(use0 ? blend(oy0, vy0) : vy0);
        m_cr = cl(use0 ? blend(ocr, vv) : vv);
        m_y1 = cl(use1 ? blend(oy1, vy1) : vy1);
      end else begin
        b = (aa % 4 == 1) ? m_y0 : (aa % 4 == 2) ? m_cr : m_y1;
      end
    end
    m_hc++;
    if (m_hc == len) begin
      m_hc = 0;
      if (m_vc == t_vb + t_al - 1) begin m_vc = 0; m_f = t_int ? !m_f : 1'b0; end
      else m_vc++;
    end
    aa = m_hc - sav - 4;
    e_vt = 0; e_ot = 0;
    if (m_hc >= sav + 4 && m_vc >= t_vb && aa % 4 == 0) begin
      e_vt = !t_up || (aa / 4) % 2 == 0;
      e_ot = t_ovl;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (running) begin
      logic [7:0] b;
      string t;
      model_step(b, t);
      q.push_back(b);
      tq.push_back(t);
    end
  end

  always @(negedge clk) begin
    if (running && q.size() > 0) begin
      logic [7:0] eb;
      string t;
      eb = q.pop_front();
      t = tq.pop_front();
      chk(dout == eb, t, dout, eb);
      chk(vid_take == e_vt, "R5", vid_take, e_vt);
      chk(ovl_take == e_ot, t_ovl ? "R8" : "R12", ovl_take, e_ot);
    end
  end

  task automatic run_case(input int cycles);
    running = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dout == 8'h10, "R1", dout, 8'h10);
    chk(vid_take == 1'b0, "R1", vid_take, 0);
    chk(ovl_take == 1'b0, "R1", ovl_take, 0);
    q.delete(); tq.delete();
    m_hc = 0; m_vc = 0; m_f = 0; m_vi = 0; m_oi = 0;
    e_vt = 0; e_ot = 0;
    rst_n = 1;
    running = 1;
    repeat (cycles) @(posedge clk);
    #3;
    running = 0;
  endtask

  initial begin
    // R2 R3 R4 R5 R11: progressive, video only
    act_tag = "R5/R11";
    t_act = 8; t_hb = 4; t_vb = 2; t_al = 3;
    run_case(420);
    // R8 R9: opaque overlay
    act_tag = "R8/R9"; t_ovl = 1; t_alpha = 255;
    run_case(300);
    // R9 R10: partial alpha with keying
    act_tag = "R9/R10"; t_alpha = 100; t_key = 1;
    t_lo = 24'h40_40_00; t_hi = 24'hC0_C0_7F;
    run_case(420);
    // R7 R12: averaging upscale, overlay off, interlaced
    act_tag = "R7/R12"; t_ovl = 0; t_key = 0; t_up = 1; t_avg = 1; t_int = 1;
    t_act = 16; t_hb = 6; t_vb = 1; t_al = 2;
    run_case(500);
    // R6 R10 R4: repeating upscale with keyed blend, interlaced
    act_tag = "R6/R10"; t_ovl = 1; t_key = 1; t_avg = 0; t_alpha = 180;
    run_case(500);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule